// File: doc/BRIEF.md
# Complementary Switch Dead-Time Sequencer

This block takes a single pulse-width command and drives two switch-control signals that must never be on together: a main output that follows the command's high phase, and an auxiliary output that covers the low phase. Each hand-over gets its own dead interval, programmed in clock cycles. On a rising command the auxiliary switch is released first, and the main switch is turned on only after the first interval. On a falling command the main switch is released first, and the auxiliary switch is turned on only after the second interval.

Either interval can be cut short by a zero-voltage-detect strobe, so the waiting switch turns on as soon as the voltage across it has collapsed. A polarity input chooses whether the auxiliary pin is driven in the sense that suits an n-type switch or inverted for a p-type switch. A low enable puts the block to sleep: the main output is held low and the auxiliary pin is released through its output-enable. After waking, the block stays quiet until it sees a fresh rising command edge. The command is assumed to be synchronous to the clock already.

Top module: `cgd_deadtime`

## Requirements
- R1: When the block is awake and a high command is sampled in the off or second-interval phase, the auxiliary switch is released at that same clock edge. The main output rises exactly D1 edges later, where D1 is the first interval value (see R3).
- R2: A low command sampled at an edge drops the main output at that edge. The auxiliary switch turns on exactly D2 edges later, where D2 is the second interval value.
- R3: An interval value equals its programmed 8-bit setting, except that a setting of 0 counts as 1. The two settings are independent, and each is taken when its interval starts.
- R4: A first-interval strobe that is high at an edge during the first interval turns the main output on at that edge. A second-interval strobe that is high at an edge during the second interval turns the auxiliary switch on at that edge. A strobe has no effect outside its interval.
- R5: A low command during the first interval abandons it, so the main output never rises. The second interval then starts from that edge.
- R6: A high command during the second interval abandons it, so the auxiliary switch never turns on. The first interval then restarts from that edge.
- R7: The auxiliary pin carries the auxiliary switch state XOR the polarity input. With the polarity input at 0, pin value 1 means the switch is on; with it at 1, pin value 0 means the switch is on. A change of polarity shows at the pin one edge later.
- R8: A low enable sampled at an edge drives main output 0, output-enable 0 and auxiliary pin 0 from that edge on, whatever the command and strobes do.
- R9: A high enable sampled in sleep raises the output-enable one edge later, with both switches off. The block then starts a sequence only on the next rising command edge. A command that is already high, or that falls, does not start one.
- R10: The main output and the auxiliary switch are never both on.
- R11: While reset is asserted, and afterwards until enable is high, the main output, the auxiliary pin and the output-enable are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low selects sleep |
| pwm_i | input | 1 | Synchronous pulse-width command |
| aux_inv_i | input | 1 | Auxiliary polarity: 0 = non-inverted, 1 = inverted |
| t1_cfg_i | input | DW | Dead interval from auxiliary release to main on, in cycles |
| t2_cfg_i | input | DW | Dead interval from main off to auxiliary on, in cycles |
| zvs1_i | input | 1 | Zero-voltage strobe that ends the first interval |
| zvs2_i | input | 1 | Zero-voltage strobe that ends the second interval |
| main_o | output | 1 | Main switch control, active high |
| aux_o | output | 1 | Auxiliary switch pin, polarity set by aux_inv_i |
| aux_oe_o | output | 1 | Auxiliary pin drive enable; low means high impedance |

## Verification
The bench builds the block with its default 8-bit interval width and programs the settings 0, 1, 2, 3, 4, 5, 20, 30 and 40. That covers the zero-maps-to-one case, single-cycle hand-overs, and intervals long enough to be cut short by a strobe or abandoned by an early command edge. Each pulse is checked by predicting the exact edge of every output change. Both polarities are used, and sleep is entered from the off and on phases, so the wake-up rule and the behaviour of the released pin are checked in both.

// File: rtl/cgd_pkg.sv
package cgd_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,
    ST_ARM   = 3'd1,
    ST_OFF   = 3'd2,
    ST_T1    = 3'd3,
    ST_ON    = 3'd4,
    ST_T2    = 3'd5
  } cgd_state_e;

  localparam int unsigned NUM_TIMERS = 2;
  localparam int unsigned TMR_MAIN   = 0;  // aux release -> main on
  localparam int unsigned TMR_AUX    = 1;  // main off -> aux on
endpackage

// File: rtl/cgd_pwm_sense.sv
module cgd_pwm_sense (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  output logic rise_o
);
  logic pwm_q;

  // reset to 1 so a command already high at reset is not taken as an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b1;
    else         pwm_q <= pwm_i;
  end

  assign rise_o = pwm_i & ~pwm_q;
endmodule

// File: rtl/cgd_dead_timer.sv
module cgd_dead_timer #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          run_i,
  input  logic [DW-1:0] cfg_i,
  input  logic          zvs_i,
  output logic          done_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] ld_val;

  // setting 0 behaves as 1: remaining count is max(cfg,1)-1
  assign ld_val = (cfg_i == '0) ? '0 : cfg_i - ONE;
  assign done_o = run_i & ((cnt_q == '0) | zvs_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= ld_val;
    else if (run_i && !done_o) cnt_q <= cnt_q - ONE;
  end

  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !done_o && !load_i) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/cgd_seq.sv
module cgd_seq
  import cgd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       pwm_i,
  input  logic       rise_i,
  input  logic       zvs1_i,
  input  logic       zvs2_i,
  input  logic [1:0] t_done_i,
  output cgd_state_e nxt_o,
  output logic [1:0] t_load_o,
  output logic [1:0] t_run_o
);
  cgd_state_e st_q, nxt;

  always_comb begin
    nxt = st_q;
    if (!en_i) begin
      nxt = ST_SLEEP;
    end else begin
      unique case (st_q)
        ST_SLEEP: nxt = ST_ARM;
        ST_ARM:   if (rise_i) nxt = ST_T1;
        ST_OFF:   if (pwm_i) nxt = ST_T1;
        ST_T1: begin
          if (!pwm_i)                   nxt = ST_T2;
          else if (t_done_i[TMR_MAIN])  nxt = ST_ON;
        end
        ST_ON:    if (!pwm_i) nxt = ST_T2;
        ST_T2: begin
          if (pwm_i)                    nxt = ST_T1;
          else if (t_done_i[TMR_AUX])   nxt = ST_OFF;
        end
        default:  nxt = ST_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_SLEEP;
    else         st_q <= nxt;
  end

  assign nxt_o = nxt;
  assign t_run_o[TMR_MAIN]  = (st_q == ST_T1);
  assign t_run_o[TMR_AUX]   = (st_q == ST_T2);
  assign t_load_o[TMR_MAIN] = (nxt == ST_T1) && (st_q != ST_T1);
  assign t_load_o[TMR_AUX]  = (nxt == ST_T2) && (st_q != ST_T2);

  p_zvs1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pwm_i && zvs1_i && st_q == ST_T1) |=> (st_q == ST_ON));
  p_zvs2_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !pwm_i && zvs2_i && st_q == ST_T2) |=> (st_q == ST_OFF));
  p_t1_abort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !pwm_i && st_q == ST_T1) |=> (st_q == ST_T2));
  p_t2_abort_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pwm_i && st_q == ST_T2) |=> (st_q == ST_T1));
  p_wake_arm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && st_q == ST_SLEEP) |=> (st_q == ST_ARM));
  p_arm_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !rise_i && st_q == ST_ARM) |=> (st_q == ST_ARM));
endmodule

// File: rtl/cgd_out_stage.sv
module cgd_out_stage
  import cgd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cgd_state_e nxt_i,
  input  logic       aux_inv_i,
  output logic       main_o,
  output logic       aux_o,
  output logic       aux_oe_o,
  output logic       aux_act_o
);
  logic main_q, act_q, oe_q, pin_q;
  logic main_d, act_d, oe_d;

  assign main_d = (nxt_i == ST_ON);
  assign act_d  = (nxt_i == ST_OFF);
  assign oe_d   = (nxt_i != ST_SLEEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= 1'b0;
      act_q  <= 1'b0;
      oe_q   <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      main_q <= main_d;
      act_q  <= act_d;
      oe_q   <= oe_d;
      pin_q  <= oe_d & (act_d ^ aux_inv_i);
    end
  end

  assign main_o    = main_q;
  assign aux_o     = pin_q;
  assign aux_oe_o  = oe_q;
  assign aux_act_o = act_q;

  p_no_overlap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(main_q && act_q));
  p_main_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(main_q) |-> $past(!act_q));
  p_aux_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(!main_q));
endmodule

// File: rtl/cgd_deadtime.sv
module cgd_deadtime
  import cgd_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          pwm_i,
  input  logic          aux_inv_i,
  input  logic [DW-1:0] t1_cfg_i,
  input  logic [DW-1:0] t2_cfg_i,
  input  logic          zvs1_i,
  input  logic          zvs2_i,
  output logic          main_o,
  output logic          aux_o,
  output logic          aux_oe_o
);
  logic          rise;
  logic [1:0]    t_load, t_run, t_done, t_zvs;
  logic [DW-1:0] t_cfg [NUM_TIMERS];
  cgd_state_e    nxt;
  logic          aux_act;

  assign t_cfg[TMR_MAIN] = t1_cfg_i;
  assign t_cfg[TMR_AUX]  = t2_cfg_i;
  assign t_zvs[TMR_MAIN] = zvs1_i;
  assign t_zvs[TMR_AUX]  = zvs2_i;

  cgd_pwm_sense u_sense (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pwm_i (pwm_i),
    .rise_o(rise)
  );

  for (genvar gi = 0; gi < NUM_TIMERS; gi++) begin : g_tmr
    cgd_dead_timer #(.DW(DW)) u_tmr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(t_load[gi]),
      .run_i (t_run[gi]),
      .cfg_i (t_cfg[gi]),
      .zvs_i (t_zvs[gi]),
      .done_o(t_done[gi])
    );
  end

  cgd_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .pwm_i   (pwm_i),
    .rise_i  (rise),
    .zvs1_i  (zvs1_i),
    .zvs2_i  (zvs2_i),
    .t_done_i(t_done),
    .nxt_o   (nxt),
    .t_load_o(t_load),
    .t_run_o (t_run)
  );

  cgd_out_stage u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .nxt_i    (nxt),
    .aux_inv_i(aux_inv_i),
    .main_o   (main_o),
    .aux_o    (aux_o),
    .aux_oe_o (aux_oe_o),
    .aux_act_o(aux_act)
  );

  p_fall_main_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_i |=> !main_o);
  p_rise_aux_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_i |=> !aux_act);
  p_sleep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!main_o && !aux_oe_o && !aux_o));
  p_reset_r11: assert property (@(posedge clk_i)
    !rst_ni |-> (!main_o && !aux_oe_o && !aux_o));
endmodule

// File: tb/cgd_deadtime_tb_top.sv
`timescale 1ns/1ps
module cgd_deadtime_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en = 1'b0, pwm = 1'b0, aux_inv = 1'b0, zvs1 = 1'b0, zvs2 = 1'b0;
  logic [7:0] t1 = 8'd3, t2 = 8'd5;
  logic       main_o, aux_o, aux_oe_o;

  int total = 0, bad = 0, ovl = 0, cyc = 0;
  logic inv_q = 1'b0;
  logic [2:0] prev = 3'b000;

  typedef struct {
    int    cyc;
    logic  m;
    logic  a;
    logic  oe;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2 clk_i = ~clk_i;

  cgd_deadtime dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .pwm_i(pwm),
    .aux_inv_i(aux_inv), .t1_cfg_i(t1), .t2_cfg_i(t2),
    .zvs1_i(zvs1), .zvs2_i(zvs2),
    .main_o(main_o), .aux_o(aux_o), .aux_oe_o(aux_oe_o)
  );

  always @(posedge clk_i) begin
    cyc   <= cyc + 1;
    inv_q <= aux_inv;
  end

  function automatic int dly(logic [7:0] v);
    return (v == 8'd0) ? 1 : int'(v);
  endfunction

  function automatic void push(int c, bit m, bit act, bit oe, string tag);
    exp_t e;
    e.cyc = c; e.m = m; e.oe = oe; e.tag = tag;
    e.a = oe ? (act ^ aux_inv) : 1'b0;
    q.push_back(e);
  endfunction

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic chk(string tag, logic [2:0] act, logic [2:0] ex);
    total++;
    if (act !== ex) begin
      bad++;
      $display("FAIL %s: {main,aux,oe} actual=%b expected=%b", tag, act, ex);
    end
  endtask

  // scoreboard monitor: every output change must match the next expected item
  always @(negedge clk_i) begin : mon
    logic [2:0] cur;
    exp_t e;
    if (rst_ni) begin
      cur = {main_o, aux_o, aux_oe_o};
      if (aux_oe_o && main_o && (aux_o ^ inv_q)) ovl++;
      if (cur !== prev) begin
        total++;
        if (q.size() == 0) begin
          bad++;
          $display("FAIL R1 R2 unexpected change at cyc=%0d: actual=%b expected=%b",
                   cyc, cur, prev);
        end else begin
          e = q.pop_front();
          if (e.cyc != cyc || e.m !== main_o || e.a !== aux_o || e.oe !== aux_oe_o) begin
            bad++;
            $display("FAIL %s: actual cyc=%0d {m,a,oe}=%b expected cyc=%0d {m,a,oe}=%b",
                     e.tag, cyc, cur, e.cyc, {e.m, e.a, e.oe});
          end
        end
        prev = cur;
      end
    end
  end

  task automatic pulse(int hi, int lo, bit from_arm, string tg);
    int c;
    c = cyc; pwm = 1'b1;
    if (!from_arm) push(c + 1, 0, 0, 1, "R1");
    push(c + 1 + dly(t1), 1, 0, 1, tg);
    repeat (hi) step();
    c = cyc; pwm = 1'b0;
    push(c + 1, 0, 0, 1, "R2");
    push(c + 1 + dly(t2), 0, 1, 1, tg);
    repeat (lo) step();
  endtask

  initial begin : watchdog
    #(100000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : drive
    int c;
    repeat (3) step();
    chk("R11 in reset", {main_o, aux_o, aux_oe_o}, 3'b000);
    rst_ni = 1'b1;
    repeat (5) step();
    chk("R11 after reset, enable low", {main_o, aux_o, aux_oe_o}, 3'b000);

    // wake, then sequence from the armed state
    c = cyc; en = 1'b1; push(c + 1, 0, 0, 1, "R9 wake");
    repeat (4) step();
    pulse(12, 10, 1'b1, "R1 R2 t1=3 t2=5");

    // minimum intervals: 0 and 1 both give one cycle (R3)
    t1 = 8'd0; t2 = 8'd1;
    pulse(6, 6, 1'b0, "R3 cfg 0/1");
    t1 = 8'd1; t2 = 8'd0;
    pulse(6, 6, 1'b0, "R3 cfg 1/0");
    t1 = 8'd40; t2 = 8'd4;
    pulse(50, 10, 1'b0, "R3 long t1");

    // early end of first interval
    t1 = 8'd30; t2 = 8'd5;
    c = cyc; pwm = 1'b1; push(c + 1, 0, 0, 1, "R1");
    step(); step();
    zvs1 = 1'b1; push(c + 3, 1, 0, 1, "R4 zvs1");
    step(); zvs1 = 1'b0;
    repeat (8) step();
    c = cyc; pwm = 1'b0; push(c + 1, 0, 0, 1, "R2"); push(c + 6, 0, 1, 1, "R2");
    repeat (10) step();

    // early end of second interval
    t1 = 8'd2; t2 = 8'd30;
    c = cyc; pwm = 1'b1; push(c + 1, 0, 0, 1, "R1"); push(c + 3, 1, 0, 1, "R1");
    repeat (8) step();
    c = cyc; pwm = 1'b0; push(c + 1, 0, 0, 1, "R2");
    repeat (3) step();
    zvs2 = 1'b1; push(c + 4, 0, 1, 1, "R4 zvs2");
    step(); zvs2 = 1'b0;
    repeat (5) step();
    // strobes outside their interval change nothing
    zvs1 = 1'b1; zvs2 = 1'b1;
    repeat (3) step();
    zvs1 = 1'b0; zvs2 = 1'b0;
    step();
    chk("R4 strobes while off", {main_o, aux_o, aux_oe_o}, 3'b011);

    // fall during first interval
    t1 = 8'd10; t2 = 8'd4;
    c = cyc; pwm = 1'b1; push(c + 1, 0, 0, 1, "R1");
    repeat (3) step();
    c = cyc; pwm = 1'b0; push(c + 5, 0, 1, 1, "R5 abort t1");
    repeat (14) step();

    // rise during second interval
    t1 = 8'd3; t2 = 8'd20;
    c = cyc; pwm = 1'b1; push(c + 1, 0, 0, 1, "R1"); push(c + 4, 1, 0, 1, "R1");
    repeat (8) step();
    c = cyc; pwm = 1'b0; push(c + 1, 0, 0, 1, "R2");
    repeat (4) step();
    c = cyc; pwm = 1'b1; push(c + 4, 1, 0, 1, "R6 abort t2");
    repeat (8) step();
    c = cyc; pwm = 1'b0; push(c + 1, 0, 0, 1, "R2"); push(c + 21, 0, 1, 1, "R2 t2=20");
    repeat (25) step();

    // inverted polarity
    c = cyc; aux_inv = 1'b1; push(c + 1, 0, 1, 1, "R7 polarity flip");
    step(); step();
    chk("R7 inverted, aux on", {main_o, aux_o, aux_oe_o}, 3'b001);
    t1 = 8'd2; t2 = 8'd2;
    pulse(12, 10, 1'b0, "R7 inverted pulse");

    // sleep from off phase, command activity ignored
    c = cyc; en = 1'b0; push(c + 1, 0, 0, 0, "R8 sleep");
    repeat (3) step();
    pwm = 1'b1; repeat (3) step(); pwm = 1'b0; repeat (3) step();
    zvs1 = 1'b1; pwm = 1'b1; repeat (3) step(); zvs1 = 1'b0;
    chk("R8 asleep", {main_o, aux_o, aux_oe_o}, 3'b000);
    c = cyc; en = 1'b1; push(c + 1, 0, 0, 1, "R9 wake high");
    repeat (6) step();
    pwm = 1'b0;
    repeat (6) step();
    chk("R9 armed, no sequence", {main_o, aux_o, aux_oe_o}, 3'b011);
    pulse(12, 10, 1'b1, "R9 first rise");

    // sleep from on phase
    c = cyc; pwm = 1'b1; push(c + 1, 0, 0, 1, "R1"); push(c + 3, 1, 0, 1, "R1");
    repeat (10) step();
    chk("R1 on phase", {main_o, aux_o, aux_oe_o}, 3'b111);
    c = cyc; en = 1'b0; push(c + 1, 0, 0, 0, "R8 sleep from on");
    repeat (3) step();
    pwm = 1'b0;
    repeat (2) step();
    c = cyc; en = 1'b1; push(c + 1, 0, 0, 1, "R9 wake low");
    repeat (4) step();
    t1 = 8'd5; t2 = 8'd3;
    pulse(12, 10, 1'b1, "R3 t1=5 t2=3");

    repeat (5) step();
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R1 R2 missing changes: actual pending=%0d expected=0", q.size());
    end
    total++;
    if (ovl != 0) begin
      bad++;
      $display("FAIL R10 overlap cycles: actual=%0d expected=0", ovl);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule